// File: doc/BRIEF.md
# Fine-Grain LRU Thread Selector

This block is the thread-select stage of a scalar pipeline that interleaves four hardware threads at single-cycle granularity. In every cycle it looks at which threads have an instruction waiting and are not blocked. It picks the one that issued least recently and raises an issue strobe with that thread's index and program counter. Moving from one thread to another costs no cycles. A thread that issued in the cycle before may be followed at once by a different one.

Each thread slot tracks its own blocking state. Issuing a load blocks the thread for the next two cycles, since load data returns in the third cycle after decode on a hit. After that, the instructions following the load issue speculatively on the assumption that it hit. When the load is reported as a miss, the block raises a replay strobe for that thread. It then parks the thread until the miss fill arrives and resumes it from the instruction right after the load. Pipeline-reported blocking (stalls from cache misses, traps, resource conflicts) holds a thread until a release. Multiply and divide hold it until the execution unit signals completion.

Top module: `lru_thread_select`

## Requirements
- R1: After reset the recency order is thread 0 (least recent) through thread 3, no thread is blocked, every thread's program counter is 0, and `issue_vld` and `replay_vld` are low when no thread offers an instruction.
- R2: In each cycle at most one instruction issues. Among the eligible threads the one earliest in the recency order is chosen, and the chosen thread moves to the most-recent end. The issuing thread may differ from cycle to cycle with no idle cycle between. `issue_tid` is the binary thread index, and bit i of every per-thread vector belongs to thread i.
- R3: When no thread is eligible, `issue_vld` is low and the recency order is left unchanged.
- R4: A thread that issues a load (`thr_is_load` high for it when chosen) is not chosen in the next two cycles and may be chosen again in the third.
- R5: Instructions after a load issue before the load is resolved. A hit response (`ld_resp_vld` high, `ld_resp_miss` low, `ld_resp_tid` naming the thread) ends the speculation with no replay and no change of program counter.
- R6: A miss response for a thread with an unresolved load raises `replay_vld` with `replay_tid` in that same cycle. The thread is not chosen in that cycle and stays blocked until a `thr_fill` pulse. It then issues again from the load's program counter plus one.
- R7: A load response for a thread with no unresolved load is ignored: no replay, no blocking.
- R8: A thread holds at most one unresolved load. If its next instruction is a load, it is not eligible until a response has been accepted in an earlier cycle.
- R9: `thr_stall` blocks its thread from the next cycle on until a `thr_release` pulse. The thread becomes eligible in the cycle after the release. When both arrive together, the stall wins.
- R10: Issuing a multiply or divide (`thr_is_long` high when chosen) blocks the thread from the next cycle until a `thr_done` pulse. The thread becomes eligible in the cycle after it.
- R11: Each thread has a PC_W-bit program counter that `issue_pc` shows for the chosen thread. It advances by one per issue of that thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_rdy | input | NTHR | Thread has an instruction waiting |
| thr_is_load | input | NTHR | Waiting instruction is a load |
| thr_is_long | input | NTHR | Waiting instruction is a multiply or divide |
| thr_stall | input | NTHR | Pipeline reports a blocking event for the thread |
| thr_release | input | NTHR | Pipeline lifts its block on the thread |
| thr_done | input | NTHR | Execution unit finished the thread's multiply/divide |
| thr_fill | input | NTHR | Miss data for the thread's load has arrived |
| ld_resp_vld | input | 1 | Hit/miss result is present |
| ld_resp_miss | input | 1 | Result is a miss (1) or a hit (0) |
| ld_resp_tid | input | TID_W | Thread the result belongs to |
| issue_vld | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Index of the issuing thread |
| issue_pc | output | PC_W | Program counter of the issuing instruction |
| replay_vld | output | 1 | Speculative instructions of a thread must be squashed |
| replay_tid | output | TID_W | Thread being squashed |

## Verification
Two functions can fall in the same cycle: a miss response and selection. The thread whose load just missed still looks ready to the selector, so the replay strobe and the issue choice both want it. The bench provokes this by keeping only the speculating thread ready while the miss is driven. It judges the cycle by requiring `replay_vld` high for that thread with `issue_vld` low, then blocked cycles, and a restart at the load's address plus one once the fill has landed. Stall plus selection in one cycle is also driven, with the stall seen to act one cycle later.

// File: rtl/thr_sel_pkg.sv
// Shared types for the thread-select stage.
package thr_sel_pkg;

    // Per-thread inbound controls, gathered from the per-thread input vectors.
    typedef struct packed {
        logic rdy;
        logic is_load;
        logic is_long;
        logic stall;
        logic release_blk;
        logic done;
        logic fill;
    } thr_ctl_t;

endpackage

// File: rtl/thr_slot.sv
// Per-thread state slot.
// Holds the thread's program counter, the load shadow counter, the
// unresolved-load marker and the three hold flags (pipeline, long op,
// miss). It reports whether the thread is free to be chosen.
// Assumes issue_me is never high in a cycle where squash is high.
module thr_slot
    import thr_sel_pkg::*;
#(
    parameter int LOAD_BLOCK = 2,
    parameter int PC_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  thr_ctl_t        ctl,
    input  logic            issue_me,
    input  logic            resp_me,
    input  logic            resp_miss,
    output logic            avail,
    output logic            ld_pend,
    output logic            squash,
    output logic [PC_W-1:0] pc
);
    localparam int CNT_W = $clog2(LOAD_BLOCK + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOAD_BLOCK);

    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  pc_q, ld_pc_q;
    logic             pend_q, stall_q, long_q, miss_q;
    logic             hit;

    // Resolve a response against this slot's unresolved load.
    always_comb begin
        squash = resp_me && resp_miss && pend_q;
        hit    = resp_me && !resp_miss && pend_q;
    end

    // Program counter, load address and unresolved-load marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            ld_pc_q <= '0;
            pend_q  <= 1'b0;
        end else if (squash) begin
            pc_q   <= ld_pc_q + 1'b1;
            pend_q <= 1'b0;
        end else begin
            if (issue_me) begin
                pc_q <= pc_q + 1'b1;
            end
            if (issue_me && ctl.is_load) begin
                pend_q  <= 1'b1;
                ld_pc_q <= pc_q;
            end else if (hit) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Load shadow: counts the cycles before load data could be back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (issue_me && ctl.is_load) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Hold flags: pipeline block, long operation, outstanding miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            long_q  <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            if (ctl.stall)            stall_q <= 1'b1;
            else if (ctl.release_blk) stall_q <= 1'b0;
            if (issue_me && ctl.is_long) long_q <= 1'b1;
            else if (ctl.done)           long_q <= 1'b0;
            if (squash)          miss_q <= 1'b1;
            else if (ctl.fill)   miss_q <= 1'b0;
        end
    end

    // Outputs seen by the selector.
    always_comb begin
        avail   = (cnt_q == '0) && !stall_q && !long_q && !miss_q;
        ld_pend = pend_q;
        pc      = pc_q;
    end

    // R4
    load_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_me && ctl.is_load |=> !avail ##1 !avail);
    // R6
    miss_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (pc_q == $past(ld_pc_q) + 1'b1) && !avail);
    // R6
    no_issue_on_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !issue_me);
endmodule

// File: rtl/lru_order.sv
// Recency list and picker.
// Keeps the threads as an ordered list, slot 0 the least recently issued.
// Picks the first eligible thread in list order. On an issue, that thread
// is removed and appended at the most-recent end. With no issue the list
// holds. Assumes elig is valid for the current cycle.
module lru_order #(
    parameter int NTHR  = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTHR-1:0]  elig,
    output logic             any,
    output logic [TID_W-1:0] pick
);
    logic [NTHR-1:0][TID_W-1:0] order_q, order_d;
    logic [TID_W-1:0]           pos;

    // Scan the list from least recent for the first eligible thread.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        pos  = '0;
        for (int k = 0; k < NTHR; k++) begin
            if (!any && elig[order_q[k]]) begin
                any  = 1'b1;
                pick = order_q[k];
                pos  = TID_W'(k);
            end
        end
    end

    // Next list: close the gap at pos, put the chosen thread last.
    always_comb begin
        for (int k = 0; k < NTHR; k++) begin
            if (k < int'(pos))   order_d[k] = order_q[k];
            else if (k < NTHR-1) order_d[k] = order_q[k+1];
            else                 order_d[k] = pick;
        end
    end

    // List register, initial order thread 0 .. thread NTHR-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTHR; k++) order_q[k] <= TID_W'(k);
        end else if (any) begin
            order_q <= order_d;
        end
    end

    // Coverage mask of the list, used by the permutation check.
    logic [NTHR-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < NTHR; k++) seen[order_q[k]] = 1'b1;
    end

    // R2
    order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {NTHR{1'b1}});
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any |=> $stable(order_q));
    // R2
    mru_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |=> order_q[NTHR-1] == $past(pick));
endmodule

// File: rtl/lru_thread_select.sv
// Thread-select stage, top level.
// One slot per hardware thread feeds eligibility to the recency picker.
// The picked thread's program counter is driven out with the issue
// strobe. A miss on an unresolved load raises the replay strobe. That
// thread is kept out of selection in the same cycle.
// Assumes at most one load response per cycle.
module lru_thread_select
    import thr_sel_pkg::*;
#(
    parameter int NTHR       = 4,
    parameter int LOAD_BLOCK = 2,
    parameter int PC_W       = 16,
    localparam int TID_W     = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTHR-1:0]  thr_rdy,
    input  logic [NTHR-1:0]  thr_is_load,
    input  logic [NTHR-1:0]  thr_is_long,
    input  logic [NTHR-1:0]  thr_stall,
    input  logic [NTHR-1:0]  thr_release,
    input  logic [NTHR-1:0]  thr_done,
    input  logic [NTHR-1:0]  thr_fill,
    input  logic             ld_resp_vld,
    input  logic             ld_resp_miss,
    input  logic [TID_W-1:0] ld_resp_tid,
    output logic             issue_vld,
    output logic [TID_W-1:0] issue_tid,
    output logic [PC_W-1:0]  issue_pc,
    output logic             replay_vld,
    output logic [TID_W-1:0] replay_tid
);
    thr_ctl_t         ctl     [NTHR];
    logic [NTHR-1:0]  avail, pend, squash, elig, issue_me, resp_me;
    logic [PC_W-1:0]  pc_all  [NTHR];

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        // Bundle this thread's controls and derive its eligibility.
        always_comb begin
            ctl[i] = '{rdy: thr_rdy[i], is_load: thr_is_load[i],
                       is_long: thr_is_long[i], stall: thr_stall[i],
                       release_blk: thr_release[i], done: thr_done[i],
                       fill: thr_fill[i]};
            resp_me[i]  = ld_resp_vld && (ld_resp_tid == TID_W'(i));
            issue_me[i] = issue_vld && (issue_tid == TID_W'(i));
            elig[i]     = thr_rdy[i] && avail[i] && !squash[i]
                          && !(thr_is_load[i] && pend[i]);
        end

        thr_slot #(
            .LOAD_BLOCK (LOAD_BLOCK),
            .PC_W       (PC_W)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (ctl[i]),
            .issue_me  (issue_me[i]),
            .resp_me   (resp_me[i]),
            .resp_miss (ld_resp_miss),
            .avail     (avail[i]),
            .ld_pend   (pend[i]),
            .squash    (squash[i]),
            .pc        (pc_all[i])
        );
    end

    lru_order #(
        .NTHR  (NTHR),
        .TID_W (TID_W)
    ) i_lru (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .any   (issue_vld),
        .pick  (issue_tid)
    );

    // Issue address and replay strobe.
    always_comb begin
        issue_pc   = pc_all[issue_tid];
        replay_vld = |squash;
        replay_tid = ld_resp_tid;
    end

    // R2
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> thr_rdy[issue_tid]);
    // R6
    replay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_vld |-> !(issue_vld && issue_tid == replay_tid));
    // R7
    replay_needs_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_vld |-> ld_resp_vld && ld_resp_miss);
endmodule

// File: tb/test_lru_thread_select.sv
`timescale 1ns/1ps
module test_lru_thread_select;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] thr_rdy, thr_is_load, thr_is_long, thr_stall;
    logic [3:0] thr_release, thr_done, thr_fill;
    logic       ld_resp_vld, ld_resp_miss;
    logic [1:0] ld_resp_tid;
    logic       issue_vld, replay_vld;
    logic [1:0] issue_tid, replay_tid;
    logic [15:0] issue_pc;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lru_thread_select i_lru_thread_select (
        .clk(clk), .rst_n(rst_n), .thr_rdy(thr_rdy), .thr_is_load(thr_is_load),
        .thr_is_long(thr_is_long), .thr_stall(thr_stall), .thr_release(thr_release),
        .thr_done(thr_done), .thr_fill(thr_fill), .ld_resp_vld(ld_resp_vld),
        .ld_resp_miss(ld_resp_miss), .ld_resp_tid(ld_resp_tid),
        .issue_vld(issue_vld), .issue_tid(issue_tid), .issue_pc(issue_pc),
        .replay_vld(replay_vld), .replay_tid(replay_tid));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        thr_rdy = '0; thr_is_load = '0; thr_is_long = '0; thr_stall = '0;
        thr_release = '0; thr_done = '0; thr_fill = '0;
        ld_resp_vld = 1'b0; ld_resp_miss = 1'b0; ld_resp_tid = '0;
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Inputs are already set for this cycle; check outputs, then advance.
    task automatic step(string req, bit v, int tid, int pc);
        #1;
        chk(req, "issue_vld", int'(issue_vld), int'(v));
        if (v) begin
            chk(req, "issue_tid", int'(issue_tid), tid);
            chk(req, "issue_pc", int'(issue_pc), pc);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", "replay_vld", int'(replay_vld), 0);
        step("R1", 1'b0, 0, 0);
        thr_rdy = 4'b1111;
        step("R1", 1'b1, 0, 0);
    endtask

    task automatic t_rotate();
        do_reset();
        thr_rdy = 4'b1111;
        step("R2", 1'b1, 0, 0);
        step("R2", 1'b1, 1, 0);
        step("R2", 1'b1, 2, 0);
        step("R2", 1'b1, 3, 0);
        step("R11", 1'b1, 0, 1);
        step("R11", 1'b1, 1, 1);
    endtask

    task automatic t_subset();
        do_reset();
        thr_rdy = 4'b0100;
        step("R2", 1'b1, 2, 0);
        thr_rdy = 4'b0000;
        step("R3", 1'b0, 0, 0);
        thr_rdy = 4'b1111;
        step("R3", 1'b1, 0, 0);
        step("R2", 1'b1, 1, 0);
        step("R2", 1'b1, 3, 0);
        step("R2", 1'b1, 2, 1);
    endtask

    task automatic t_load_shadow();
        do_reset();
        thr_rdy = 4'b0011; thr_is_load = 4'b0001;
        step("R4", 1'b1, 0, 0);
        thr_is_load = 4'b0000;
        step("R4", 1'b1, 1, 0);
        step("R4", 1'b1, 1, 1);
        step("R4", 1'b1, 0, 1);
    endtask

    task automatic t_miss_replay();
        do_reset();
        thr_rdy = 4'b0001; thr_is_load = 4'b0001;
        step("R4", 1'b1, 0, 0);
        thr_is_load = 4'b0000;
        step("R4", 1'b0, 0, 0);
        step("R4", 1'b0, 0, 0);
        step("R5", 1'b1, 0, 1);
        step("R5", 1'b1, 0, 2);
        ld_resp_vld = 1'b1; ld_resp_miss = 1'b1; ld_resp_tid = 2'd0;
        #1;
        chk("R6", "replay_vld", int'(replay_vld), 1);
        chk("R6", "replay_tid", int'(replay_tid), 0);
        step("R6", 1'b0, 0, 0);
        clear_in(); thr_rdy = 4'b0001;
        step("R6", 1'b0, 0, 0);
        step("R6", 1'b0, 0, 0);
        thr_fill = 4'b0001;
        step("R6", 1'b0, 0, 0);
        thr_fill = 4'b0000;
        step("R6", 1'b1, 0, 1);
    endtask

    task automatic t_hit_one_load();
        do_reset();
        thr_rdy = 4'b0001; thr_is_load = 4'b0001;
        step("R8", 1'b1, 0, 0);
        step("R4", 1'b0, 0, 0);
        step("R4", 1'b0, 0, 0);
        step("R8", 1'b0, 0, 0);
        ld_resp_vld = 1'b1; ld_resp_miss = 1'b0; ld_resp_tid = 2'd0;
        #1;
        chk("R5", "replay_vld", int'(replay_vld), 0);
        step("R8", 1'b0, 0, 0);
        ld_resp_vld = 1'b0;
        step("R5", 1'b1, 0, 1);
    endtask

    task automatic t_ignored_resp();
        do_reset();
        thr_rdy = 4'b1111;
        ld_resp_vld = 1'b1; ld_resp_miss = 1'b1; ld_resp_tid = 2'd2;
        #1;
        chk("R7", "replay_vld", int'(replay_vld), 0);
        step("R7", 1'b1, 0, 0);
        ld_resp_vld = 1'b0;
        step("R7", 1'b1, 1, 0);
        step("R7", 1'b1, 2, 0);
    endtask

    task automatic t_stall();
        do_reset();
        thr_rdy = 4'b0010; thr_stall = 4'b0001;
        step("R9", 1'b1, 1, 0);
        thr_rdy = 4'b1111; thr_stall = 4'b0000;
        step("R9", 1'b1, 2, 0);
        step("R9", 1'b1, 3, 0);
        step("R9", 1'b1, 1, 1);
        thr_rdy = 4'b0001; thr_release = 4'b0001;
        step("R9", 1'b0, 0, 0);
        thr_release = 4'b0000;
        step("R9", 1'b1, 0, 0);
    endtask

    task automatic t_long();
        do_reset();
        thr_rdy = 4'b0011; thr_is_long = 4'b0001;
        step("R10", 1'b1, 0, 0);
        thr_is_long = 4'b0000; thr_rdy = 4'b0001;
        step("R10", 1'b0, 0, 0);
        step("R10", 1'b0, 0, 0);
        thr_done = 4'b0001;
        step("R10", 1'b0, 0, 0);
        thr_done = 4'b0000;
        step("R10", 1'b1, 0, 1);
    endtask

    initial begin
        clear_in();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_rotate();
        t_subset();
        t_load_shadow();
        t_miss_replay();
        t_hit_one_load();
        t_ignored_resp();
        t_stall();
        t_long();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule